// File: doc/BRIEF.md
# Enable-Paced UART Transmitter

This block turns one 8-bit parallel byte into an asynchronous serial frame on a single output line. The frame is a low start bit, eight data bits sent least significant first, an optional parity bit, and a high stop bit. A state machine with one state per frame position drives the line. The block runs entirely on the system clock. The bit rate comes from an external single-cycle enable strobe (`tick_i`), and the machine moves to its next state only on clock edges where that strobe is high. Because of this, the same block serves any baud rate without a derived or gated clock.

A host presents a byte, its parity settings and a send request. The request is taken in the idle state on an edge where the strobe is also high. At that edge the byte and the parity settings are captured, so the inputs are free to change for the rest of the frame. The busy output covers the whole frame. A one-clock done pulse marks the end of the stop bit period.

Top module: `uart_tx_ce`

## Requirements
- R1: While `rst_ni` is low, `txd_o` is 1 and `busy_o` and `done_o` are 0.
- R2: In the idle state `txd_o` is held at 1 and `busy_o` is 0.
- R3: The state of the frame changes only on clock edges where `tick_i` is 1. Between strobes, `txd_o` and `busy_o` hold their values.
- R4: In the idle state, an edge with both `send_i` and `tick_i` at 1 accepts a request. That edge captures `data_i`, `par_en_i` and `par_odd_i`, and after it `txd_o` is 0 (the start bit) and `busy_o` is 1.
- R5: After the start bit, each following strobe puts the next data bit on `txd_o`, bit 0 first and bit 7 last.
- R6: When the captured `par_en_i` is 1, a parity bit follows bit 7. If the captured `par_odd_i` is 1, the count of ones in the data plus parity is odd; if it is 0, the count is even.
- R7: When the captured `par_en_i` is 0, the strobe after bit 7 goes straight to the stop bit.
- R8: The stop bit is 1. The next strobe returns the block to idle.
- R9: `done_o` is 1 for exactly the one clock that follows the edge ending the stop bit period, and `busy_o` is 0 in that clock. `busy_o` stays 1 from the start bit through the stop bit.
- R10: While busy, `send_i` and changes on `data_i`, `par_en_i` and `par_odd_i` have no effect on the frame in progress.
- R11: A request with `tick_i` low, or a strobe with `send_i` low, leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to send |
| send_i | input | 1 | Transmit request |
| par_en_i | input | 1 | Append a parity bit |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| tick_i | input | 1 | Single-cycle bit-rate enable strobe |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock pulse at the end of the stop bit |

## Verification
The bench sends several kinds of frames and checks each bit period:
- Bytes with alternating bits, all ones, all zeros, and a single set top bit. These separate a correct least-significant-first order from a reversed or shifted order, and they show whether each data bit has its own state.
- Frames with parity off, even parity and odd parity. These show that the parity state is skipped when off and that the parity sense is correct.
- Strobes one cycle apart and strobes with idle gaps between them. These confirm that the output holds between strobes.
- Frames where the host keeps `send_i` high and flips the byte and the parity controls mid-frame. These show that the inputs are captured at the accepting edge.
- A reset in the middle of a frame.
- Requests without a strobe, and strobes without a request.

// File: rtl/uart_tx_ce_pkg.sv
package uart_tx_ce_pkg;
  localparam int DATA_W = 8;
  localparam int ST_W   = 4;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 4'd0,
    ST_START = 4'd1,
    ST_D0    = 4'd2,
    ST_D1    = 4'd3,
    ST_D2    = 4'd4,
    ST_D3    = 4'd5,
    ST_D4    = 4'd6,
    ST_D5    = 4'd7,
    ST_D6    = 4'd8,
    ST_D7    = 4'd9,
    ST_PAR   = 4'd10,
    ST_STOP  = 4'd11
  } tx_state_e;
endpackage

// File: rtl/uart_tx_ce_seq.sv
module uart_tx_ce_seq
  import uart_tx_ce_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            send_i,
  input  logic            par_en_i,
  output logic [ST_W-1:0] state_o,
  output logic            accept_o,
  output logic            frame_end_o
);
  tx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (tick_i) begin
      unique case (state_q)
        ST_IDLE:  if (send_i) state_d = ST_START;
        ST_START: state_d = ST_D0;
        ST_D0, ST_D1, ST_D2, ST_D3, ST_D4, ST_D5, ST_D6:
                  state_d = tx_state_e'(state_q + 4'd1);
        ST_D7:    state_d = par_en_i ? ST_PAR : ST_STOP;
        ST_PAR:   state_d = ST_STOP;
        ST_STOP:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign accept_o    = (state_q == ST_IDLE) && tick_i && send_i;
  assign frame_end_o = (state_q == ST_STOP) && tick_i;
endmodule

// File: rtl/uart_tx_ce_frame.sv
module uart_tx_ce_frame #(
  parameter int DATA_W = uart_tx_ce_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic [DATA_W-1:0] data_q_o,
  output logic              par_en_q_o,
  output logic              par_bit_o
);
  logic [DATA_W-1:0] data_q;
  logic              par_en_q, par_odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
    end else if (accept_i) begin
      data_q    <= data_i;
      par_en_q  <= par_en_i;
      par_odd_q <= par_odd_i;
    end
  end

  assign data_q_o   = data_q;
  assign par_en_q_o = par_en_q;
  // even: parity equals XOR of data; odd flips it
  assign par_bit_o  = (^data_q) ^ par_odd_q;
endmodule

// File: rtl/uart_tx_ce_mux.sv
module uart_tx_ce_mux
  import uart_tx_ce_pkg::*;
#(
  parameter int DATA_W = uart_tx_ce_pkg::DATA_W
) (
  input  logic [ST_W-1:0]   state_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  output logic              txd_o
);
  logic [DATA_W-1:0] bit_sel;

  for (genvar k = 0; k < DATA_W; k++) begin : g_sel
    assign bit_sel[k] = (state_i == ST_W'(int'(ST_D0) + k));
  end

  always_comb begin
    if (|bit_sel) txd_o = |(bit_sel & data_i);
    else if (state_i == ST_START) txd_o = 1'b0;
    else if (state_i == ST_PAR)   txd_o = par_bit_i;
    else                          txd_o = 1'b1;
  end
endmodule

// File: rtl/uart_tx_ce.sv
module uart_tx_ce
  import uart_tx_ce_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              send_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [ST_W-1:0]   state_q;
  logic              accept, frame_end, par_en_q, par_bit;
  logic [DATA_W-1:0] data_q;
  logic              done_q;

  uart_tx_ce_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .send_i      (send_i),
    .par_en_i    (par_en_q),
    .state_o     (state_q),
    .accept_o    (accept),
    .frame_end_o (frame_end)
  );

  uart_tx_ce_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .data_i     (data_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .data_q_o   (data_q),
    .par_en_q_o (par_en_q),
    .par_bit_o  (par_bit)
  );

  uart_tx_ce_mux #(.DATA_W(DATA_W)) u_mux (
    .state_i   (state_q),
    .data_i    (data_q),
    .par_bit_i (par_bit),
    .txd_o     (txd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= frame_end;
  end

  assign done_o = done_q;
  assign busy_o = (state_q != ST_W'(ST_IDLE));
endmodule

// File: rtl/uart_tx_ce_chk.sv
module uart_tx_ce_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       send_i,
  input logic       txd_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [3:0] state_i
);
  a_r1_legal_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i <= 4'd11);

  a_r2_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(txd_o) && $stable(busy_o)));

  a_r4_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_ends_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r10_busy_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && send_i && !tick_i) |=> busy_o);

  a_r11_no_tick_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !tick_i) |=> !busy_o);
endmodule

bind uart_tx_ce uart_tx_ce_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .send_i  (send_i),
  .txd_o   (txd_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .state_i (state_q)
);

// File: tb/uart_tx_ce_bench.sv
module uart_tx_ce_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       send_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0, tick_i = 1'b0;
  logic       txd_o, busy_o, done_o;
  int         n_chk = 0, n_fail = 0;
  bit         ended = 1'b0;

  always #2 clk_i = ~clk_i;

  uart_tx_ce u_uart_tx_ce (
    .clk_i, .rst_ni, .data_i, .send_i, .par_en_i, .par_odd_i, .tick_i,
    .txd_o, .busy_o, .done_o
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // drive tick for one cycle, return at the next negedge
  task automatic cyc(input logic t);
    tick_i = t;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                            input int gap, input bit disturb);
    logic exp_bits[10];
    int   n;
    for (int k = 0; k < 8; k++) exp_bits[k] = d[k];
    n = 8;
    if (pen) begin exp_bits[8] = (^d) ^ podd; n = 9; end
    exp_bits[n] = 1'b1;
    n++;
    data_i = d; par_en_i = pen; par_odd_i = podd; send_i = 1'b1;
    cyc(1);
    if (disturb) begin
      data_i = ~d; par_en_i = ~pen; par_odd_i = ~podd;  // R10 stays held
    end else send_i = 1'b0;
    chk("R4 start bit", txd_o, 1'b0);
    chk("R9 busy at start", busy_o, 1'b1);
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < gap; g++) begin
        cyc(0);
        chk("R3 hold between ticks", txd_o, (k == 0) ? 1'b0 : exp_bits[k-1]);
      end
      cyc(1);
      if (k < 8)       chk("R5 data bit", txd_o, exp_bits[k]);
      else if (k == n-1) chk("R8 stop bit", txd_o, 1'b1);
      else             chk("R6 parity bit", txd_o, exp_bits[k]);
      if (k == 8 && !pen) chk("R7 stop right after bit 7", busy_o, 1'b1);
      chk("R10 busy through frame", busy_o, 1'b1);
    end
    for (int g = 0; g < gap; g++) cyc(0);
    chk("R9 done not early", done_o, 1'b0);
    cyc(1);
    send_i = 1'b0;
    chk("R9 done pulse", done_o, 1'b1);
    chk("R8 back to idle", busy_o, 1'b0);
    chk("R2 idle high", txd_o, 1'b1);
    cyc(0);
    chk("R9 done one clock", done_o, 1'b0);
    chk("R10 no restart", busy_o, 1'b0);
  endtask

  task automatic idle_noise();
    send_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc(0);
      chk("R11 request without tick", busy_o, 1'b0);
      chk("R2 idle high", txd_o, 1'b1);
    end
    send_i = 1'b0;
    cyc(1);
    chk("R11 tick without request", busy_o, 1'b0);
  endtask

  task automatic mid_reset();
    data_i = 8'h00; par_en_i = 1'b0; send_i = 1'b1;
    cyc(1);
    send_i = 1'b0;
    cyc(1); cyc(1);
    chk("R5 zero bit before reset", txd_o, 1'b0);
    rst_ni = 1'b0;
    #1;
    chk("R1 reset txd", txd_o, 1'b1);
    chk("R1 reset busy", busy_o, 1'b0);
    chk("R1 reset done", done_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(0);
    chk("R2 idle after reset", busy_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset txd", txd_o, 1'b1);
    chk("R1 reset busy", busy_o, 1'b0);
    chk("R1 reset done", done_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_noise();
    send_frame(8'hA5, 1'b0, 1'b0, 0, 1'b0);
    send_frame(8'h55, 1'b1, 1'b0, 2, 1'b0);
    send_frame(8'hFF, 1'b1, 1'b1, 1, 1'b0);
    send_frame(8'h00, 1'b1, 1'b1, 0, 1'b0);
    send_frame(8'h80, 1'b1, 1'b0, 3, 1'b1);
    send_frame(8'h3C, 1'b0, 1'b1, 1, 1'b1);
    mid_reset();
    send_frame(8'h01, 1'b1, 1'b0, 0, 1'b0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule